// File: doc/BRIEF.md
# Per-Core Interrupt Controller Register Bank

This block is the register storage behind the software-visible side of a per-core interrupt controller. A synchronous port carries an index, write data, a write strobe and a read strobe. Each index is classified into a register kind, and each kind has its own write rule. Some rules mask the written data, some force bits high, some ignore writes completely, and some keep selected bits of the stored value. Read data is registered and appears one cycle after the read strobe.

The bank also keeps a small internal state word with two live bits. The first is a software-enable bit, loaded whenever the spurious-vector register is written. The second is an arm flag that controls a two-step clearing handshake on the error-status register. A read of the error-status register also clears the arm flag. Indices that are not implemented read as zero, discard writes and raise a one-cycle flag.

The index map is: 0 core ID, 1 version, 2 task priority, 3 logical destination, 4 destination format, 5 spurious vector, 6 error status, 7 to 12 the six local vector entries (timer, thermal, performance counter, local pin 0, local pin 1, error), 13 initial count, 14 current count, 15 divide configuration, 16 state word. Indices 17 and above are unimplemented.

Top module: `lic_regbank`

## Requirements
- R1: After reset every index 0 to 16 reads zero, except the version index 1, which reads the VERSION_WORD parameter; sw_enable is low.
- R2: A write to the core ID (0) or task priority (2) stores only data bits 7:0 and stores zero in all other bits.
- R3: A write to the logical destination (3) stores only bits 31:24 and stores zero in the lower bits.
- R4: A write to the destination format (4) stores bits 31:28 as written and stores ones in bits 27:0.
- R5: Writes to the version (1) and current count (14) indices leave their read values unchanged.
- R6: A write to any local vector entry (7 to 12) leaves bits 12 and 14 at their stored value and stores all other bits as written.
- R7: A write to the spurious vector (5) stores all 32 bits and copies data bit 8 into sw_enable, visible the cycle after the write.
- R8: A write to error status (6) while the arm flag is clear sets the flag and leaves the register unchanged. A write while the flag is set clears the flag and stores zero.
- R9: A read of error status (6) clears the arm flag.
- R10: A write to the divide configuration (15) keeps only the bits selected by mask 0xB.
- R11: An access to an index of 17 or above reads zero and discards writes. It also drives unimpl high in the cycle after the access, and low after a cycle with no such access.
- R12: rd_data is updated one cycle after rd_en with the value held before any write in the same cycle, and holds its value while rd_en is low.
- R13: The state word (16) reads the arm flag in bit 0 and sw_enable in bit 8, with zero elsewhere; writes to it are ignored.
- R14: A write to the initial count (13) stores all 32 bits as written.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| idx | input | IDX_W | Register index |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 32 | Registered read data |
| unimpl | output | 1 | One-cycle flag for an access to an unimplemented index |
| sw_enable | output | 1 | Software-enable bit of the internal state word |

## Verification
Every masking register is written with all ones and then with a mixed pattern. All ones shows which bits a rule clears or forces. The mixed pattern tells a correct mask apart from a shifted mask or from a plain store. The local vector entries are written with all ones and then with only bits 12 and 14 set, which separates preserving those two bits from storing or clearing them. The error-status handshake runs through arm, disarm, re-arm and read-clear, and the state word is read after each step, so the order of the two-step rule is pinned down. Unimplemented indices, idle cycles and a read issued in the same cycle as a write to the same index show the flag timing and the rule that a read returns the old value.

// File: rtl/lic_pkg.sv
package lic_pkg;

    localparam int unsigned DATA_W     = 32;
    localparam int unsigned NUM_STORED = 16;
    localparam int unsigned SLOT_W     = $clog2(NUM_STORED);
    localparam int unsigned SWEN_BIT   = 8;

    // index map
    localparam int unsigned IX_ID    = 0;
    localparam int unsigned IX_VER   = 1;
    localparam int unsigned IX_TPRI  = 2;
    localparam int unsigned IX_LDEST = 3;
    localparam int unsigned IX_DFMT  = 4;
    localparam int unsigned IX_SPUR  = 5;
    localparam int unsigned IX_ESTAT = 6;
    localparam int unsigned IX_LVT0  = 7;
    localparam int unsigned NUM_LVT  = 6;
    localparam int unsigned IX_ICNT  = 13;
    localparam int unsigned IX_CCNT  = 14;
    localparam int unsigned IX_DIV   = 15;
    localparam int unsigned IX_STATE = 16;

    localparam logic [DATA_W-1:0] MASK_LOW8   = 32'h0000_00FF;
    localparam logic [DATA_W-1:0] MASK_TOP8   = 32'hFF00_0000;
    localparam logic [DATA_W-1:0] FORCE_FMT   = 32'h0FFF_FFFF;
    localparam logic [DATA_W-1:0] LVT_KEEP    = 32'h0000_5000;
    localparam logic [DATA_W-1:0] MASK_DIV    = 32'h0000_000B;

    typedef enum logic [3:0] {
        K_PLAIN,
        K_LOW8,
        K_TOP8,
        K_FMT,
        K_RO,
        K_LVT,
        K_SPUR,
        K_ERR,
        K_DIV,
        K_STATE,
        K_NONE
    } reg_kind_e;

endpackage

// File: rtl/lic_idx_dec.sv
module lic_idx_dec
    import lic_pkg::*;
#(
    parameter int unsigned IDX_W = 6
) (
    input  logic [IDX_W-1:0] idx,
    output reg_kind_e        kind
);

    logic [31:0] idx_w;

    always_comb begin
        idx_w = 32'(idx);
        if (idx_w >= IX_LVT0 && idx_w < IX_LVT0 + NUM_LVT) begin
            kind = K_LVT;
        end else begin
            case (idx_w)
                IX_ID, IX_TPRI:  kind = K_LOW8;
                IX_VER, IX_CCNT: kind = K_RO;
                IX_LDEST:        kind = K_TOP8;
                IX_DFMT:         kind = K_FMT;
                IX_SPUR:         kind = K_SPUR;
                IX_ESTAT:        kind = K_ERR;
                IX_ICNT:         kind = K_PLAIN;
                IX_DIV:          kind = K_DIV;
                IX_STATE:        kind = K_STATE;
                default:         kind = K_NONE;
            endcase
        end
    end

endmodule

// File: rtl/lic_wr_rule.sv
module lic_wr_rule
    import lic_pkg::*;
(
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] cur,
    input  logic              arm,
    output logic              commit,
    output logic [DATA_W-1:0] new_val,
    output logic              arm_set,
    output logic              arm_clr,
    output logic              swen_ld
);

    always_comb begin
        commit  = 1'b1;
        new_val = wdata;
        arm_set = 1'b0;
        arm_clr = 1'b0;
        swen_ld = 1'b0;
        case (kind)
            K_PLAIN: new_val = wdata;
            K_LOW8:  new_val = wdata & MASK_LOW8;
            K_TOP8:  new_val = wdata & MASK_TOP8;
            K_FMT:   new_val = wdata | FORCE_FMT;
            K_LVT:   new_val = (wdata & ~LVT_KEEP) | (cur & LVT_KEEP);
            K_DIV:   new_val = wdata & MASK_DIV;
            K_SPUR: begin
                new_val = wdata;
                swen_ld = 1'b1;
            end
            K_ERR: begin
                if (arm) begin
                    new_val = '0;
                    arm_clr = 1'b1;
                end else begin
                    commit  = 1'b0;
                    arm_set = 1'b1;
                end
            end
            default: commit = 1'b0;
        endcase
    end

endmodule

// File: rtl/lic_rd_mux.sv
module lic_rd_mux
    import lic_pkg::*;
(
    input  reg_kind_e                           kind,
    input  logic [SLOT_W-1:0]                   slot,
    input  logic [NUM_STORED-1:0][DATA_W-1:0]   regs,
    input  logic                                arm,
    input  logic                                sw_en,
    output logic [DATA_W-1:0]                   rdata
);

    always_comb begin
        case (kind)
            K_NONE:  rdata = '0;
            K_STATE: begin
                rdata           = '0;
                rdata[0]        = arm;
                rdata[SWEN_BIT] = sw_en;
            end
            default: rdata = regs[slot];
        endcase
    end

endmodule

// File: rtl/lic_regbank.sv
module lic_regbank
    import lic_pkg::*;
#(
    parameter int unsigned       IDX_W        = 6,
    parameter logic [31:0]       VERSION_WORD = 32'h0005_0014
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] idx,
    input  logic             wr_en,
    input  logic [31:0]      wr_data,
    input  logic             rd_en,
    output logic [31:0]      rd_data,
    output logic             unimpl,
    output logic             sw_enable
);

    typedef struct packed {
        logic [NUM_STORED-1:0][DATA_W-1:0] regs;
        logic                              arm;
        logic                              sw_en;
        logic [DATA_W-1:0]                 rdata;
        logic                              unimpl;
    } bank_t;

    bank_t st_d, st_q;

    reg_kind_e         kind;
    logic [SLOT_W-1:0] slot;
    logic              commit, arm_set, arm_clr, swen_ld;
    logic [DATA_W-1:0] new_val, rd_word;

    assign slot = idx[SLOT_W-1:0];

    lic_idx_dec #(.IDX_W(IDX_W)) u_dec (
        .idx  (idx),
        .kind (kind)
    );

    lic_wr_rule u_wr (
        .kind    (kind),
        .wdata   (wr_data),
        .cur     (st_q.regs[slot]),
        .arm     (st_q.arm),
        .commit  (commit),
        .new_val (new_val),
        .arm_set (arm_set),
        .arm_clr (arm_clr),
        .swen_ld (swen_ld)
    );

    lic_rd_mux u_rd (
        .kind  (kind),
        .slot  (slot),
        .regs  (st_q.regs),
        .arm   (st_q.arm),
        .sw_en (st_q.sw_en),
        .rdata (rd_word)
    );

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (commit)  st_d.regs[slot] = new_val;
            if (arm_set) st_d.arm = 1'b1;
            if (arm_clr) st_d.arm = 1'b0;
            if (swen_ld) st_d.sw_en = wr_data[SWEN_BIT];
        end
        if (rd_en) begin
            st_d.rdata = rd_word;
            if (kind == K_ERR) st_d.arm = 1'b0;
        end
        st_d.unimpl = (rd_en || wr_en) && (kind == K_NONE);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q              <= '0;
            st_q.regs[IX_VER] <= VERSION_WORD;
        end else begin
            st_q <= st_d;
        end
    end

    assign rd_data   = st_q.rdata;
    assign unimpl    = st_q.unimpl;
    assign sw_enable = st_q.sw_en;

endmodule

// File: rtl/lic_regbank_chk.sv
module lic_regbank_chk #(
    parameter int unsigned IDX_W        = 6,
    parameter logic [31:0] VERSION_WORD = 32'h0005_0014
) (
    input logic             clk,
    input logic             rst_n,
    input logic [IDX_W-1:0] idx,
    input logic             wr_en,
    input logic             wd_bit8,
    input logic             rd_en,
    input logic [31:0]      rd_data,
    input logic             unimpl,
    input logic             sw_enable
);

    logic idx_none;
    assign idx_none = 32'(idx) >= 17;

    // R11
    unimpl_raise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en || wr_en) && idx_none |=> unimpl);

    // R11
    unimpl_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(rd_en || wr_en) |=> !unimpl);

    // R11
    unimpl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && idx_none |=> rd_data == 32'h0);

    // R5
    version_const_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && 32'(idx) == 1 |=> rd_data == VERSION_WORD);

    // R7
    swen_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && 32'(idx) == 5 |=> sw_enable == $past(wd_bit8));

    // R12
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rd_data));

    // R13
    state_swen_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en && 32'(idx) == 16 |=> rd_data[8] == $past(sw_enable));

endmodule

bind lic_regbank lic_regbank_chk #(
    .IDX_W        (IDX_W),
    .VERSION_WORD (VERSION_WORD)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .idx       (idx),
    .wr_en     (wr_en),
    .wd_bit8   (wr_data[8]),
    .rd_en     (rd_en),
    .rd_data   (rd_data),
    .unimpl    (unimpl),
    .sw_enable (sw_enable)
);

// File: tb/lic_regbank_bench.sv
module lic_regbank_bench;

    localparam logic [31:0] VER = 32'h0005_0014;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [5:0]  idx = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        rd_en = 1'b0;
    logic [31:0] rd_data;
    logic        unimpl;
    logic        sw_enable;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    lic_regbank #(.IDX_W(6), .VERSION_WORD(VER)) u_lic_regbank (
        .clk       (clk),
        .rst_n     (rst_n),
        .idx       (idx),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .unimpl    (unimpl),
        .sw_enable (sw_enable)
    );

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
        end
    endtask

    task automatic wr(input int i, input logic [31:0] d);
        @(negedge clk);
        idx = 6'(i); wr_data = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input int i, output logic [31:0] v);
        @(negedge clk);
        idx = 6'(i); rd_en = 1'b1;
        @(negedge clk);
        rd_en = 1'b0;
        v = rd_data;
    endtask

    task automatic t_reset();
        logic [31:0] v;
        for (int i = 0; i <= 16; i++) begin
            rd(i, v);
            chk("R1", $sformatf("reset idx %0d", i), v, (i == 1) ? VER : 32'h0);
        end
        chk("R1", "reset sw_enable", 32'(sw_enable), 32'h0);
    endtask

    task automatic t_masks();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2", "id ones", v, 32'h0000_00FF);
        wr(2, 32'h1234_5678); rd(2, v); chk("R2", "tpri mixed", v, 32'h0000_0078);
        wr(3, 32'hFFFF_FFFF); rd(3, v); chk("R3", "ldest ones", v, 32'hFF00_0000);
        wr(3, 32'h1234_5678); rd(3, v); chk("R3", "ldest mixed", v, 32'h1200_0000);
        wr(4, 32'h5000_0000); rd(4, v); chk("R4", "dfmt high", v, 32'h5FFF_FFFF);
        wr(4, 32'h0000_0000); rd(4, v); chk("R4", "dfmt zero", v, 32'h0FFF_FFFF);
        wr(15, 32'hFFFF_FFFF); rd(15, v); chk("R10", "div ones", v, 32'h0000_000B);
        wr(15, 32'h0000_0006); rd(15, v); chk("R10", "div mixed", v, 32'h0000_0002);
        wr(13, 32'hA5C3_0F96); rd(13, v); chk("R14", "icnt full", v, 32'hA5C3_0F96);
    endtask

    task automatic t_readonly();
        logic [31:0] v;
        wr(1, 32'h0000_0000); rd(1, v); chk("R5", "version after write", v, VER);
        wr(14, 32'hDEAD_BEEF); rd(14, v); chk("R5", "ccnt after write", v, 32'h0);
        wr(16, 32'hFFFF_FFFF); rd(16, v); chk("R13", "state after write", v, 32'h0);
    endtask

    task automatic t_lvt();
        logic [31:0] v;
        for (int i = 7; i <= 12; i++) begin
            wr(i, 32'hFFFF_FFFF); rd(i, v);
            chk("R6", $sformatf("lvt %0d ones", i), v, 32'hFFFF_AFFF);
            wr(i, 32'h0000_5000); rd(i, v);
            chk("R6", $sformatf("lvt %0d keep bits", i), v, 32'h0);
        end
    endtask

    task automatic t_spur();
        logic [31:0] v;
        wr(5, 32'h8000_01FF);
        chk("R7", "sw_enable set", 32'(sw_enable), 32'h1);
        rd(5, v); chk("R7", "spur full", v, 32'h8000_01FF);
        rd(16, v); chk("R13", "state swen", v, 32'h0000_0100);
        wr(5, 32'h0000_00FF);
        chk("R7", "sw_enable clear", 32'(sw_enable), 32'h0);
    endtask

    task automatic t_err();
        logic [31:0] v;
        rd(16, v); chk("R8", "arm idle", v, 32'h0);
        wr(6, 32'hFFFF_FFFF); rd(16, v); chk("R8", "first write arms", v, 32'h1);
        wr(6, 32'hFFFF_FFFF); rd(16, v); chk("R8", "second write disarms", v, 32'h0);
        wr(6, 32'h1234_0000); rd(16, v); chk("R8", "re-arm", v, 32'h1);
        rd(6, v); chk("R8", "estat value", v, 32'h0);
        rd(16, v); chk("R9", "read clears arm", v, 32'h0);
        wr(6, 32'h0); rd(16, v); chk("R9", "write after read-clear arms", v, 32'h1);
        rd(6, v);
    endtask

    task automatic t_unimpl();
        logic [31:0] v;
        wr(20, 32'hFFFF_FFFF);
        chk("R11", "pulse on write", 32'(unimpl), 32'h1);
        @(negedge clk);
        chk("R11", "pulse drops", 32'(unimpl), 32'h0);
        rd(20, v);
        chk("R11", "read zero", v, 32'h0);
        chk("R11", "pulse on read", 32'(unimpl), 32'h1);
        rd(63, v);
        chk("R11", "top index zero", v, 32'h0);
        rd(0, v);
        chk("R11", "no pulse on implemented", 32'(unimpl), 32'h0);
    endtask

    task automatic t_rdtiming();
        logic [31:0] v;
        rd(0, v);
        repeat (3) @(negedge clk);
        chk("R12", "hold while idle", rd_data, 32'h0000_00FF);
        @(negedge clk);
        idx = 6'(2); wr_data = 32'h0000_0033; wr_en = 1'b1; rd_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; rd_en = 1'b0;
        chk("R12", "same-cycle read old", rd_data, 32'h0000_0078);
        rd(2, v); chk("R12", "write landed", v, 32'h0000_0033);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_masks();
        t_readonly();
        t_lvt();
        t_spur();
        t_err();
        t_unimpl();
        t_rdtiming();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule